// File: doc/BRIEF.md
# Power-Line Command Frame Receiver

This block rebuilds one house/key command from the receive pulses that a carrier-current modem produces on a mains line. It sees only one thing: the falling edge of the modem's receive line. It times the interval between successive edges with a microsecond tick and turns each interval into a data bit. The interval is judged in whole multiples of a nominal mains half-cycle, and the meaning of each multiple depends on the previous bit.

A frame opens with a three-pulse start pattern, one half-cycle apart. The trailing zero of the start code is assumed rather than observed. Nine data bits follow. The upper four bits form the raw house code and the lower five bits form the raw key code. Each code is translated to a number through a fixed inverse table. The block reports start-code faults, intervals that fit no rule, and frames cut short by silence through an error flag. It also marks frames that began while the local transmitter was active.

The result leaves on a valid/ready stream. Once `res_valid` rises, the flags, house and key stay stable until a cycle where `res_ready` is also high. Back-pressure never stalls reception. A frame that completes while an unconsumed result is held is discarded, and `overrun` is raised instead. If the held result is consumed in the same cycle a new frame completes, the new result is taken and no overrun is raised.

Top module: `pl_cmd_rx`

## Requirements
- R1: After reset `res_valid` and `overrun` are 0, and the receiver waits idle for a first pulse.
- R2: Outside idle, a falling edge that comes less than MIN_GAP_US ticks after the last accepted pulse is ignored. It does not count as a pulse and does not restart interval timing.
- R3: The first pulse in idle opens a frame. The second and third pulses must each arrive one half-cycle after the previous one. Otherwise an error result is emitted and the receiver returns to idle.
- R4: An interval matches k half-cycles when it differs from k*HALF_US by strictly less than HALF_US/6 (integer division). With HALF_US=60 this means 69 is accepted and 70 is rejected.
- R5: For each data bit, if the previous bit was 1, an interval of 2 half-cycles gives 1 and 3 gives 0. If the previous bit was 0, 1 gives 1 and 2 gives 0. The previous bit for the first data bit is 1. Any other interval emits an error result.
- R6: The nine data bits arrive MSB first. Raw bits [8:5] are the house code and map through {12,4,2,10,14,6,0,8,13,5,3,11,15,7,1,9}. Raw bits [4:0] are the key code and map through {12,16,4,17,2,18,10,19,14,20,6,21,0,22,8,23,13,24,5,25,3,26,11,27,15,28,7,29,1,30,9,31}.
- R7: In `res_flags`, bit 0 is the level of `tx_active` at the frame's first pulse and bit 1 marks an error. Bits 7:2 are 0. On error, house and key are 0.
- R8: If no pulse arrives for SILENCE_US ticks during a frame, the frame is abandoned. A frame with only one pulse is dropped without output. Any longer partial frame emits an error result.
- R9: While `res_valid` is high and `res_ready` is low, the valid signal and all result fields hold their values. A cycle with both high consumes the result.
- R10: A frame that completes while a result is held and not consumed is discarded, and `overrun` is set until the next consuming cycle. A frame that completes in a consuming cycle replaces the result and leaves `overrun` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| us_tick | input | 1 | One-cycle strobe per microsecond |
| rx_in | input | 1 | Modem receive line; each falling edge is a pulse |
| tx_active | input | 1 | High while the local transmitter is sending |
| res_ready | input | 1 | Consumer accepts the result |
| res_valid | output | 1 | Result held and available |
| res_flags | output | 8 | Bit 0 local, bit 1 error |
| res_house | output | 8 | House number 0..15 |
| res_key | output | 8 | Key number 0..31 |
| overrun | output | 1 | A completed frame was discarded while a result was held |

## Verification
The completion of a new frame and the consumption of the held result can fall in the same clock edge. The bench holds a first result with `res_ready` low. It then raises `res_ready` in exactly the cycle where the last data pulse of a second frame is sampled. It expects the second frame's house and key in the held result and `overrun` at 0. A separate case leaves `res_ready` low through the second completion and expects the first result to survive with `overrun` high.

// File: rtl/pl_rx_pkg.sv
package pl_rx_pkg;

  localparam int HOUSE_W    = 4;
  localparam int KEY_W      = 5;
  localparam int DATA_BITS  = HOUSE_W + KEY_W;
  localparam int START_ONES = 3;
  localparam int FLAG_LOCAL = 0;
  localparam int FLAG_ERR   = 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA
  } rx_state_e;

  localparam logic [HOUSE_W-1:0] HOUSE_LUT [2**HOUSE_W] = '{
    4'd12, 4'd4, 4'd2, 4'd10, 4'd14, 4'd6, 4'd0, 4'd8,
    4'd13, 4'd5, 4'd3, 4'd11, 4'd15, 4'd7, 4'd1, 4'd9
  };

  localparam logic [KEY_W-1:0] KEY_LUT [2**KEY_W] = '{
    5'd12, 5'd16, 5'd4,  5'd17, 5'd2,  5'd18, 5'd10, 5'd19,
    5'd14, 5'd20, 5'd6,  5'd21, 5'd0,  5'd22, 5'd8,  5'd23,
    5'd13, 5'd24, 5'd5,  5'd25, 5'd3,  5'd26, 5'd11, 5'd27,
    5'd15, 5'd28, 5'd7,  5'd29, 5'd1,  5'd30, 5'd9,  5'd31
  };

  function automatic logic [HOUSE_W-1:0] house_num(input logic [HOUSE_W-1:0] raw);
    return HOUSE_LUT[raw];
  endfunction

  function automatic logic [KEY_W-1:0] key_num(input logic [KEY_W-1:0] raw);
    return KEY_LUT[raw];
  endfunction

endpackage

// File: rtl/pl_gap_timer.sv
// Falling-edge detect on the receive line plus a saturating microsecond
// counter measuring time since the last accepted pulse.
module pl_gap_timer #(
  parameter int GAP_W = 17,
  parameter int SAT   = 50000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_tick,
  input  logic             rx_in,
  input  logic             clear,
  output logic             fall,
  output logic [GAP_W-1:0] gap_now
);

  localparam logic [GAP_W-1:0] SAT_V = GAP_W'(SAT);

  logic             rx_q;
  logic [GAP_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_q <= 1'b0;
    else        rx_q <= rx_in;
  end

  assign fall = rx_q & ~rx_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (clear)                  cnt <= '0;
    else if (us_tick && cnt != SAT_V) cnt <= cnt + 1'b1;
  end

  // Include the tick of the current cycle so the value equals the number
  // of ticks from the last accepted pulse up to and including now.
  assign gap_now = cnt + {{(GAP_W-1){1'b0}}, us_tick};

endmodule

// File: rtl/pl_gap_class.sv
// Classifies the current interval against 1..NMUL half-cycles, the minimum
// pulse spacing and the silence limit.
module pl_gap_class #(
  parameter int GAP_W      = 17,
  parameter int HALF_US    = 8333,
  parameter int MIN_GAP_US = 1500,
  parameter int SILENCE_US = 50000,
  parameter int NMUL       = 3
) (
  input  logic [GAP_W-1:0] gap,
  output logic [NMUL-1:0]  near,
  output logic             too_short,
  output logic             silent
);

  localparam int unsigned TOL = HALF_US / 6;

  logic [31:0] g32;
  assign g32 = 32'(gap);

  for (genvar k = 0; k < NMUL; k++) begin : g_mul
    localparam int unsigned CEN = (k + 1) * HALF_US;
    localparam logic [31:0] LO  = 32'(CEN - TOL);
    localparam logic [31:0] HI  = 32'(CEN + TOL);
    assign near[k] = (g32 > LO) && (g32 < HI);
  end

  assign too_short = g32 < 32'(MIN_GAP_US);
  assign silent    = g32 >= 32'(SILENCE_US);

endmodule

// File: rtl/pl_frame_ctl.sv
// Frame sequencer: start-code check, bit decode from interval, timeout.
module pl_frame_ctl
  import pl_rx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fall,
  input  logic [2:0]           near,
  input  logic                 too_short,
  input  logic                 silent,
  input  logic                 tx_active,
  output logic                 take,
  output logic                 done,
  output logic                 done_err,
  output logic                 done_loc,
  output logic [DATA_BITS-1:0] done_raw
);

  localparam int CNT_W = $clog2(DATA_BITS + 1);

  rx_state_e            st, st_n;
  logic [CNT_W-1:0]     cnt, cnt_n;
  logic [DATA_BITS-1:0] sh, sh_n;
  logic                 last, last_n;
  logic                 loc, loc_n;
  logic                 bit_one, bit_zero, nb, pulse;

  assign pulse    = fall && !too_short;
  assign bit_one  = last ? near[1] : near[0];
  assign bit_zero = last ? near[2] : near[1];
  assign done_loc = loc;

  always_comb begin
    st_n     = st;
    cnt_n    = cnt;
    sh_n     = sh;
    last_n   = last;
    loc_n    = loc;
    take     = 1'b0;
    done     = 1'b0;
    done_err = 1'b0;
    done_raw = '0;
    nb       = 1'b0;
    case (st)
      ST_IDLE: begin
        if (fall) begin
          take  = 1'b1;
          st_n  = ST_START;
          cnt_n = CNT_W'(1);
          loc_n = tx_active;
        end
      end
      ST_START: begin
        if (pulse) begin
          take = 1'b1;
          if (near[0]) begin
            if (cnt == CNT_W'(START_ONES - 1)) begin
              st_n   = ST_DATA;
              cnt_n  = '0;
              sh_n   = '0;
              last_n = 1'b1;
            end else begin
              cnt_n = cnt + 1'b1;
            end
          end else begin
            done     = 1'b1;
            done_err = 1'b1;
            st_n     = ST_IDLE;
          end
        end else if (silent) begin
          st_n = ST_IDLE;
          if (cnt > CNT_W'(1)) begin
            done     = 1'b1;
            done_err = 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (pulse) begin
          take = 1'b1;
          if (bit_one || bit_zero) begin
            nb     = bit_one;
            sh_n   = {sh[DATA_BITS-2:0], nb};
            last_n = nb;
            cnt_n  = cnt + 1'b1;
            if (cnt == CNT_W'(DATA_BITS - 1)) begin
              done     = 1'b1;
              done_raw = {sh[DATA_BITS-2:0], nb};
              st_n     = ST_IDLE;
            end
          end else begin
            done     = 1'b1;
            done_err = 1'b1;
            st_n     = ST_IDLE;
          end
        end else if (silent) begin
          done     = 1'b1;
          done_err = 1'b1;
          st_n     = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      sh   <= '0;
      last <= 1'b0;
      loc  <= 1'b0;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      sh   <= sh_n;
      last <= last_n;
      loc  <= loc_n;
    end
  end

endmodule

// File: rtl/pl_result_hold.sv
// Holds the decoded result on a valid/ready stream and flags overruns.
module pl_result_hold
  import pl_rx_pkg::*;
#(
  parameter int OUT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 done,
  input  logic                 done_err,
  input  logic                 done_loc,
  input  logic [DATA_BITS-1:0] done_raw,
  input  logic                 res_ready,
  output logic                 res_valid,
  output logic [OUT_W-1:0]     res_flags,
  output logic [OUT_W-1:0]     res_house,
  output logic [OUT_W-1:0]     res_key,
  output logic                 overrun
);

  logic             hs, load;
  logic [OUT_W-1:0] flags_n, house_n, key_n;

  assign hs   = res_valid && res_ready;
  assign load = done && (!res_valid || hs);

  always_comb begin
    flags_n             = '0;
    flags_n[FLAG_LOCAL] = done_loc;
    flags_n[FLAG_ERR]   = done_err;
    if (done_err) begin
      house_n = '0;
      key_n   = '0;
    end else begin
      house_n = OUT_W'(house_num(done_raw[DATA_BITS-1:KEY_W]));
      key_n   = OUT_W'(key_num(done_raw[KEY_W-1:0]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_flags <= '0;
      res_house <= '0;
      res_key   <= '0;
      overrun   <= 1'b0;
    end else if (load) begin
      res_valid <= 1'b1;
      res_flags <= flags_n;
      res_house <= house_n;
      res_key   <= key_n;
      overrun   <= 1'b0;
    end else if (done) begin
      overrun <= 1'b1;
    end else if (hs) begin
      res_valid <= 1'b0;
      overrun   <= 1'b0;
    end
  end

endmodule

// File: rtl/pl_cmd_rx.sv
module pl_cmd_rx
  import pl_rx_pkg::*;
#(
  parameter int HALF_US    = 8333,
  parameter int MIN_GAP_US = 1500,
  parameter int SILENCE_US = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  input  logic       rx_in,
  input  logic       tx_active,
  input  logic       res_ready,
  output logic       res_valid,
  output logic [7:0] res_flags,
  output logic [7:0] res_house,
  output logic [7:0] res_key,
  output logic       overrun
);

  localparam int GAP_W = $clog2(SILENCE_US + 1) + 1;
  localparam int NMUL  = 3;

  logic                 fall, take, too_short, silent;
  logic [GAP_W-1:0]     gap_now;
  logic [NMUL-1:0]      near;
  logic                 done, done_err, done_loc;
  logic [DATA_BITS-1:0] done_raw;

  pl_gap_timer #(
    .GAP_W (GAP_W),
    .SAT   (SILENCE_US)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .us_tick (us_tick),
    .rx_in   (rx_in),
    .clear   (take),
    .fall    (fall),
    .gap_now (gap_now)
  );

  pl_gap_class #(
    .GAP_W      (GAP_W),
    .HALF_US    (HALF_US),
    .MIN_GAP_US (MIN_GAP_US),
    .SILENCE_US (SILENCE_US),
    .NMUL       (NMUL)
  ) u_class (
    .gap       (gap_now),
    .near      (near),
    .too_short (too_short),
    .silent    (silent)
  );

  pl_frame_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .fall      (fall),
    .near      (near),
    .too_short (too_short),
    .silent    (silent),
    .tx_active (tx_active),
    .take      (take),
    .done      (done),
    .done_err  (done_err),
    .done_loc  (done_loc),
    .done_raw  (done_raw)
  );

  pl_result_hold #(
    .OUT_W (8)
  ) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .done_err  (done_err),
    .done_loc  (done_loc),
    .done_raw  (done_raw),
    .res_ready (res_ready),
    .res_valid (res_valid),
    .res_flags (res_flags),
    .res_house (res_house),
    .res_key   (res_key),
    .overrun   (overrun)
  );

endmodule

// File: rtl/pl_cmd_rx_chk.sv
module pl_cmd_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       res_ready,
  input logic       res_valid,
  input logic [7:0] res_flags,
  input logic [7:0] res_house,
  input logic [7:0] res_key,
  input logic       overrun
);

  a_r7_reserved_flags: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_flags[7:2] == 6'd0);

  a_r7_error_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_flags[1]) |-> (res_house == 8'd0 && res_key == 8'd0));

  a_r6_number_range: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_house < 8'd16 && res_key < 8'd32));

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_flags) && $stable(res_house) && $stable(res_key)));

  a_r10_overrun_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> res_valid);

  a_r10_overrun_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> !overrun);

endmodule

bind pl_cmd_rx pl_cmd_rx_chk u_chk (.*);

// File: tb/pl_cmd_rx_test.sv
`timescale 1ns/1ps
module pl_cmd_rx_test;

  localparam int H   = 60;
  localparam int MG  = 10;
  localparam int SIL = 360;

  localparam int HM [16] = '{12,4,2,10,14,6,0,8,13,5,3,11,15,7,1,9};
  localparam int KM [32] = '{12,16,4,17,2,18,10,19,14,20,6,21,0,22,8,23,
                             13,24,5,25,3,26,11,27,15,28,7,29,1,30,9,31};

  typedef struct packed {
    logic [8:0] raw;
    logic       loc;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{9'b000000000, 1'b0},
    '{9'b111111111, 1'b1},
    '{9'b011001100, 1'b0},
    '{9'b101010101, 1'b1},
    '{9'b000111110, 1'b0},
    '{9'b110100011, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       us_tick = 1'b1;
  logic       rx_in = 1'b1;
  logic       tx_active = 1'b0;
  logic       res_ready = 1'b0;
  logic       res_valid, overrun;
  logic [7:0] res_flags, res_house, res_key;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pl_cmd_rx #(.HALF_US(H), .MIN_GAP_US(MG), .SILENCE_US(SIL)) uut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .rx_in(rx_in),
    .tx_active(tx_active), .res_ready(res_ready), .res_valid(res_valid),
    .res_flags(res_flags), .res_house(res_house), .res_key(res_key),
    .overrun(overrun)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Pulse whose falling edge is sampled n cycles after the previous one.
  task automatic send_gap(input int n, input bit rdy);
    repeat (n - 1) @(negedge clk);
    rx_in = 1'b0;
    if (rdy) res_ready = 1'b1;
    @(negedge clk);
    rx_in = 1'b1;
    if (rdy) res_ready = 1'b0;
  endtask

  task automatic send_frame(input logic [8:0] raw, input int g2, input int gl, input bit hs_last);
    bit prev;
    logic b;
    send_gap(5, 0);
    if (gl > 0) begin
      send_gap(gl, 0);
      send_gap(g2 - gl, 0);
    end else begin
      send_gap(g2, 0);
    end
    send_gap(H, 0);
    prev = 1'b1;
    for (int i = 8; i >= 0; i--) begin
      b = raw[i];
      send_gap(prev ? (b ? 2*H : 3*H) : (b ? H : 2*H), (i == 0) && hs_last);
      prev = b;
    end
  endtask

  task automatic consume();
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  task automatic chk_ok(input string req, input logic [8:0] raw, input int loc);
    chk(req, res_valid, 1);
    chk(req, res_flags, loc);
    chk(req, res_house, HM[raw[8:5]]);
    chk(req, res_key, KM[raw[4:0]]);
  endtask

  task automatic chk_err(input string req, input int loc);
    chk(req, res_valid, 1);
    chk(req, res_flags, 2 + loc);
    chk(req, res_house, 0);
    chk(req, res_key, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while held in reset
    chk("R1", res_valid, 0);
    chk("R1", overrun, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", res_valid, 0);

    // Table of frames: R5 decode, R6 mapping, R7 local flag
    for (int v = 0; v < NV; v++) begin
      tx_active = VECS[v].loc;
      send_frame(VECS[v].raw, H, 0, 0);
      tx_active = 1'b0;
      chk_ok("R6", VECS[v].raw, int'(VECS[v].loc));
      consume();
      chk("R9", res_valid, 0);
    end

    // R9: result held while not ready
    send_frame(9'b100110011, H, 0, 0);
    repeat (7) @(negedge clk);
    chk_ok("R9", 9'b100110011, 0);
    consume();
    chk("R9", res_valid, 0);

    // R2: glitch 3 ticks after the second start pulse is ignored
    send_frame(9'b010101010, H, 3, 0);
    chk_ok("R2", 9'b010101010, 0);
    consume();

    // R4: tolerance boundaries accepted on the second start interval
    send_frame(9'b001100110, H + 9, 0, 0);
    chk_ok("R4", 9'b001100110, 0);
    consume();
    send_frame(9'b111000111, H - 9, 0, 0);
    chk_ok("R4", 9'b111000111, 0);
    consume();

    // R4 / R3: interval H+10 rejected, start-code error
    send_gap(5, 0);
    send_gap(H + 10, 0);
    chk_err("R4", 0);
    consume();

    // R3: second pulse two half-cycles late
    send_gap(5, 0);
    send_gap(2 * H, 0);
    chk_err("R3", 0);
    consume();

    // R5: data interval of 4 half-cycles is an error, local flag kept (R7)
    tx_active = 1'b1;
    send_gap(5, 0);
    tx_active = 1'b0;
    send_gap(H, 0);
    send_gap(H, 0);
    send_gap(4 * H, 0);
    chk_err("R5", 1);
    consume();

    // R8: single isolated pulse dropped silently
    send_gap(5, 0);
    repeat (SIL + 40) @(negedge clk);
    chk("R8", res_valid, 0);
    send_frame(9'b000011111, H, 0, 0);
    chk_ok("R8", 9'b000011111, 0);
    consume();

    // R8: two pulses then silence gives an error result
    send_gap(5, 0);
    send_gap(H, 0);
    repeat (SIL + 40) @(negedge clk);
    chk_err("R8", 0);
    consume();

    // R10: second frame completes while first held -> overrun
    send_frame(9'b011100001, H, 0, 0);
    send_frame(9'b100011110, H, 0, 0);
    chk("R10", overrun, 1);
    chk_ok("R10", 9'b011100001, 0);
    consume();
    chk("R10", res_valid, 0);
    chk("R10", overrun, 0);

    // R10: completion coincides with consumption -> replaced, no overrun
    send_frame(9'b011100001, H, 0, 0);
    send_frame(9'b100011110, H, 0, 1);
    chk("R10", overrun, 0);
    chk_ok("R10", 9'b100011110, 0);
    consume();
    chk("R10", res_valid, 0);

    report();
  end

endmodule